// File: doc/BRIEF.md
# Transmitter Watchdog and Inter-Message Gap Timer

This block sits beside the transmit path of a serial bus controller and measures two durations on a shared microsecond time base. First, it watches how long the transmitter stays active without a break. When that run passes a fixed limit of 680 µs, it raises a fail-safe shutdown flag. The flag stays set until a reset or a start command clears it.

Second, after each message completes, it times the minimum idle gap before the next message may begin. A two-bit select chooses the gap length. Once the gap has elapsed, the block also waits for a memory-ready indication, because several memory accesses must finish inside the gap. It then emits a one-cycle gap-done pulse.

A test control lets software deliberately overrun the limit. When this control is set and a controller-to-terminal message with a word count of 1 to 31 starts, the block holds the transmitter on until the watchdog trips.

Top module: `xmit_guard`

## Requirements
- R1: With the transmitter continuously active (`tx_active` or `tx_hold` high), `shutdown` rises after the clock edge that samples the 681st tick. A run of exactly 680 ticks leaves it low.
- R2: The run counter clears in any cycle where the transmitter is inactive. It advances only on cycles where `us_tick` is high, so clock cycles without a tick never trip the watchdog.
- R3: `shutdown` is 0 out of reset. Once set, it stays set regardless of transmitter activity until `rst` or `start_cmd` is high at a clock edge. Each of these clears it, together with `tx_hold` and the gap timer.
- R4: Suppose `force_overrun` is 1, `msg_bc2rt` is 1 and `msg_wcount` is nonzero (the value 0 stands for a 32-word message) on the cycle `tx_active` rises. Then `tx_hold` is 1 from the next cycle. It stays 1 while `tx_active` is low, until the cycle after `shutdown` rises.
- R5: `tx_hold` never rises if `force_overrun` is 0, if `msg_wcount` is 0, or if `msg_bc2rt` is 0 when `tx_active` rises. In these cases a short transmission never causes `shutdown`.
- R6: `gap_sel`, sampled with `msg_done`, selects the number of gap ticks: 0 selects 4, 1 selects 8, 2 selects 16 and 3 selects 32. With a tick every cycle and `mem_ready` held high, `gap_done` is seen high after the (ticks+1)th edge following the `msg_done` edge.
- R7: After the gap ticks have elapsed, `gap_done` is held off until `mem_ready` is 1 at a clock edge.
- R8: A tick on the same cycle as `msg_done` is not counted. `gap_done` is high for exactly one cycle per completed gap.
- R9: `gap_done` is never asserted while `shutdown` is set.
- R10: A `msg_done` arriving while a gap is running restarts the gap, using the newly sampled `gap_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cmd | input | 1 | Controller start; clears shutdown, hold and gap state |
| us_tick | input | 1 | One-cycle 1 µs tick from the shared time base |
| tx_active | input | 1 | Transmitter is driving the bus |
| msg_bc2rt | input | 1 | Current message is controller-to-terminal |
| msg_wcount | input | 5 | Word count of current message (0 means 32) |
| force_overrun | input | 1 | Test control: force a transmit overrun |
| msg_done | input | 1 | One-cycle message-complete strobe |
| gap_sel | input | 2 | Minimum gap select (4/8/16/32 µs) |
| mem_ready | input | 1 | Memory accesses for the next message are finished |
| tx_hold | output | 1 | Keep the transmitter on (forced overrun) |
| shutdown | output | 1 | Latched fail-safe shutdown flag |
| gap_done | output | 1 | One-cycle pulse: next message may start |

## Verification
The hardest condition to reach is the tripped watchdog. It needs more than 680 consecutive ticks of activity, and its forced-overrun variant must stay tripped after `tx_active` has already dropped. The bench reaches it by ticking every cycle and, for the forced case, by raising `tx_active` for only a few cycles under the overrun control, then letting `tx_hold` carry the run. A cycle-level reference model written from the requirements is compared on every cycle. The sweep covers all gap selects, two tick rates and delayed memory-ready.

// File: rtl/xg_pkg.sv
package xg_pkg;

    localparam int unsigned WDOG_LIMIT_DEF = 680;
    localparam int unsigned GAP_BASE_DEF   = 4;
    localparam int unsigned WCNT_W_DEF     = 5;
    localparam int unsigned GSEL_W         = 2;

    typedef enum logic [1:0] {
        GAP_IDLE = 2'd0,
        GAP_RUN  = 2'd1,
        GAP_WAIT = 2'd2
    } gap_state_t;

    typedef struct packed {
        logic                  bc2rt;
        logic [WCNT_W_DEF-1:0] wcount;
    } msg_info_t;

    function automatic logic overrun_eligible(input msg_info_t m);
        return m.bc2rt && (m.wcount != '0);
    endfunction

    function automatic int unsigned gap_len(input int unsigned base,
                                            input logic [GSEL_W-1:0] sel);
        return base << sel;
    endfunction

endpackage

// File: rtl/xg_watchdog.sv
module xg_watchdog
    import xg_pkg::*;
#(
    parameter int unsigned LIMIT = WDOG_LIMIT_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic start_cmd,
    input  logic us_tick,
    input  logic active,
    output logic shutdown
);
    localparam int unsigned CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] run_cnt;
    logic          trip_sd;

    always_ff @(posedge clk) begin
        if (rst || start_cmd) begin
            run_cnt <= '0;
            trip_sd <= 1'b0;
        end else begin
            if (!active) begin
                run_cnt <= '0;
            end else if (us_tick && run_cnt <= LIM) begin
                run_cnt <= run_cnt + 1'b1;
            end
            if (active && us_tick && run_cnt == LIM) begin
                trip_sd <= 1'b1;
            end
        end
    end

    assign shutdown = trip_sd;

    AST_TRIP_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (active && us_tick && run_cnt == LIM && !start_cmd) |=> shutdown); // R1
    AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!active) |=> (run_cnt == '0)); // R2
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && !us_tick && !start_cmd) |=> $stable(run_cnt)); // R2
    AST_SD_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (shutdown && !start_cmd) |=> shutdown); // R3

endmodule

// File: rtl/xg_overrun_ctl.sv
module xg_overrun_ctl
    import xg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_cmd,
    input  logic      tx_active,
    input  logic      force_overrun,
    input  msg_info_t msg,
    input  logic      shutdown,
    output logic      tx_hold
);
    logic tx_q;
    logic hold_q;
    logic tx_rise;

    assign tx_rise = tx_active && !tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= 1'b0;
        end else begin
            tx_q <= tx_active;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || start_cmd || shutdown) begin
            hold_q <= 1'b0;
        end else if (tx_rise && force_overrun && overrun_eligible(msg)) begin
            hold_q <= 1'b1;
        end
    end

    assign tx_hold = hold_q;

    AST_HOLD_NEEDS_FORCE: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_hold) |-> ($past(force_overrun) && $past(tx_active))); // R5
    AST_HOLD_DROPS_ON_SD: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> !tx_hold); // R4

endmodule

// File: rtl/xg_gap_timer.sv
module xg_gap_timer
    import xg_pkg::*;
#(
    parameter int unsigned BASE = GAP_BASE_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_cmd,
    input  logic              us_tick,
    input  logic              msg_done,
    input  logic [GSEL_W-1:0] gap_sel,
    input  logic              mem_ready,
    input  logic              shutdown,
    output logic              gap_done
);
    localparam int unsigned MAXLEN = BASE << ((1 << GSEL_W) - 1);
    localparam int unsigned CW     = $clog2(MAXLEN + 1);

    gap_state_t    state;
    logic [CW-1:0] tick_cnt;
    logic [CW-1:0] len_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst || start_cmd) begin
            state    <= GAP_IDLE;
            tick_cnt <= '0;
            len_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (msg_done) begin
                state    <= GAP_RUN;
                tick_cnt <= '0;
                len_q    <= CW'(gap_len(BASE, gap_sel));
            end else begin
                unique case (state)
                    GAP_RUN: begin
                        if (us_tick) begin
                            tick_cnt <= tick_cnt + 1'b1;
                            if (tick_cnt + 1'b1 == len_q) begin
                                state <= GAP_WAIT;
                            end
                        end
                    end
                    GAP_WAIT: begin
                        if (mem_ready && !shutdown) begin
                            done_q <= 1'b1;
                            state  <= GAP_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign gap_done = done_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        gap_done |=> !gap_done); // R8
    AST_DONE_AFTER_MEM: assert property (@(posedge clk) disable iff (rst)
        gap_done |-> $past(mem_ready)); // R7
    AST_NO_DONE_IN_SD: assert property (@(posedge clk) disable iff (rst)
        gap_done |-> !$past(shutdown)); // R9
    AST_RESTART_RUNS: assert property (@(posedge clk) disable iff (rst)
        (msg_done && !start_cmd) |=> (state == GAP_RUN && tick_cnt == '0)); // R10

endmodule

// File: rtl/xmit_guard.sv
module xmit_guard
    import xg_pkg::*;
#(
    parameter int unsigned WDOG_LIMIT = WDOG_LIMIT_DEF,
    parameter int unsigned GAP_BASE   = GAP_BASE_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_cmd,
    input  logic                  us_tick,
    input  logic                  tx_active,
    input  logic                  msg_bc2rt,
    input  logic [WCNT_W_DEF-1:0] msg_wcount,
    input  logic                  force_overrun,
    input  logic                  msg_done,
    input  logic [GSEL_W-1:0]     gap_sel,
    input  logic                  mem_ready,
    output logic                  tx_hold,
    output logic                  shutdown,
    output logic                  gap_done
);
    msg_info_t msg;
    logic      hold_w;
    logic      sd_w;
    logic      active_w;

    assign msg.bc2rt  = msg_bc2rt;
    assign msg.wcount = msg_wcount;
    assign active_w   = tx_active || hold_w;

    xg_overrun_ctl u_ovr (
        .clk           (clk),
        .rst           (rst),
        .start_cmd     (start_cmd),
        .tx_active     (tx_active),
        .force_overrun (force_overrun),
        .msg           (msg),
        .shutdown      (sd_w),
        .tx_hold       (hold_w)
    );

    xg_watchdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
        .clk       (clk),
        .rst       (rst),
        .start_cmd (start_cmd),
        .us_tick   (us_tick),
        .active    (active_w),
        .shutdown  (sd_w)
    );

    xg_gap_timer #(.BASE(GAP_BASE)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .start_cmd (start_cmd),
        .us_tick   (us_tick),
        .msg_done  (msg_done),
        .gap_sel   (gap_sel),
        .mem_ready (mem_ready),
        .shutdown  (sd_w),
        .gap_done  (gap_done)
    );

    assign tx_hold  = hold_w;
    assign shutdown = sd_w;

endmodule

// File: tb/xmit_guard_test.sv
`timescale 1ns/1ps
module xmit_guard_test;
    localparam int LIMIT = 680;
    localparam int BASE  = 4;

    logic       clk = 1'b0;
    logic       rst, start_cmd, us_tick, tx_active, msg_bc2rt;
    logic [4:0] msg_wcount;
    logic       force_overrun, msg_done, mem_ready;
    logic [1:0] gap_sel;
    logic       tx_hold, shutdown, gap_done;

    always #2 clk = ~clk;

    xmit_guard uut (
        .clk(clk), .rst(rst), .start_cmd(start_cmd), .us_tick(us_tick),
        .tx_active(tx_active), .msg_bc2rt(msg_bc2rt), .msg_wcount(msg_wcount),
        .force_overrun(force_overrun), .msg_done(msg_done), .gap_sel(gap_sel),
        .mem_ready(mem_ready), .tx_hold(tx_hold), .shutdown(shutdown),
        .gap_done(gap_done)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R3";
    int    tick_div = 1;
    int    tphase   = 0;
    int    ncyc     = 0;
    bit    finished = 0;

    // reference model state
    int m_cnt = 0; bit m_sd = 0; bit m_hold = 0; bit m_txq = 0;
    int g_st = 0; int g_cnt = 0; int g_len = 0; bit g_done = 0;

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, ncyc);
        end
    endtask

    task automatic model_step();
        int  n_cnt; bit n_sd, n_hold, n_done; int n_st, n_gc, n_len;
        bit  act;
        n_cnt = m_cnt; n_sd = m_sd; n_hold = m_hold;
        n_st = g_st; n_gc = g_cnt; n_len = g_len; n_done = 0;
        act = tx_active || m_hold;
        if (rst || start_cmd) begin
            n_cnt = 0; n_sd = 0; n_hold = 0; n_st = 0; n_gc = 0; n_len = 0;
        end else begin
            if (!act) n_cnt = 0;
            else if (us_tick && m_cnt <= LIMIT) begin
                if (m_cnt == LIMIT) n_sd = 1;
                n_cnt = m_cnt + 1;
            end
            if (m_sd) n_hold = 0;
            else if (tx_active && !m_txq && force_overrun && msg_bc2rt && msg_wcount != 0)
                n_hold = 1;
            if (msg_done) begin
                n_st = 1; n_gc = 0; n_len = BASE * (1 << gap_sel);
            end else if (g_st == 1) begin
                if (us_tick) begin
                    n_gc = g_cnt + 1;
                    if (n_gc == g_len) n_st = 2;
                end
            end else if (g_st == 2) begin
                if (mem_ready && !m_sd) begin n_done = 1; n_st = 0; end
            end
        end
        m_txq = rst ? 1'b0 : tx_active;
        m_cnt = n_cnt; m_sd = n_sd; m_hold = n_hold;
        g_st = n_st; g_cnt = n_gc; g_len = n_len; g_done = n_done;
    endtask

    task automatic cyc();
        us_tick = (tick_div > 0) && (tphase % tick_div == 0);
        tphase++;
        @(posedge clk);
        model_step();
        #1;
        ncyc++;
        check(cur_req, "shutdown", shutdown, m_sd);
        check(cur_req, "tx_hold",  tx_hold,  m_hold);
        check(cur_req, "gap_done", gap_done, g_done);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic do_start();
        start_cmd = 1; cyc(); start_cmd = 0; cyc();
    endtask

    initial begin
        rst = 1; start_cmd = 0; us_tick = 0; tx_active = 0; msg_bc2rt = 0;
        msg_wcount = 0; force_overrun = 0; msg_done = 0; mem_ready = 1; gap_sel = 0;
        #1;
        run(3);
        rst = 0;
        cur_req = "R3";
        check("R3", "reset shutdown", shutdown, 0);
        check("R3", "reset gap_done", gap_done, 0);
        check("R3", "reset tx_hold", tx_hold, 0);
        run(2);

        // R1: 680 ticks hold, 681 trips
        cur_req = "R1"; tick_div = 1; tphase = 0;
        tx_active = 1; run(LIMIT); tx_active = 0; run(2);
        check("R1", "no trip at 680", shutdown, 0);
        tx_active = 1; run(LIMIT + 1); tx_active = 0;
        run(1);
        check("R1", "trip at 681", shutdown, 1);

        // R3: latch until start
        cur_req = "R3"; run(30);
        check("R3", "latched", shutdown, 1);
        do_start();
        check("R3", "cleared by start", shutdown, 0);

        // R2: breaks and tick gating
        cur_req = "R2"; tick_div = 3; tphase = 0;
        tx_active = 1; run(400 * 3); tx_active = 0; run(1);
        tx_active = 1; run(400 * 3); tx_active = 0; run(1);
        check("R2", "break clears run", shutdown, 0);
        tick_div = 0; tx_active = 1; run(1000); tx_active = 0; run(1);
        check("R2", "no ticks no trip", shutdown, 0);

        // R4: forced overrun
        cur_req = "R4"; tick_div = 1; tphase = 0;
        force_overrun = 1; msg_bc2rt = 1; msg_wcount = 5;
        tx_active = 1; run(8); tx_active = 0;
        check("R4", "hold after rise", tx_hold, 1);
        run(LIMIT + 10);
        check("R4", "forced trip", shutdown, 1);
        check("R4", "hold released", tx_hold, 0);
        do_start();

        // R5: not eligible
        cur_req = "R5";
        msg_wcount = 0; tx_active = 1; run(5); tx_active = 0; run(40);
        check("R5", "wcount 0 no hold", tx_hold, 0);
        msg_wcount = 31; msg_bc2rt = 0; tx_active = 1; run(5); tx_active = 0; run(40);
        check("R5", "rt2bc no hold", tx_hold, 0);
        msg_bc2rt = 1; force_overrun = 0; tx_active = 1; run(5); tx_active = 0; run(40);
        check("R5", "force clear no hold", tx_hold, 0);
        check("R5", "no shutdown", shutdown, 0);

        // R6: direct latency per select
        cur_req = "R6"; tick_div = 1; mem_ready = 1;
        for (int s = 0; s < 4; s++) begin
            int lat; bit seen;
            gap_sel = 2'(s); msg_done = 1; cyc(); msg_done = 0;
            lat = 0; seen = 0;
            for (int k = 0; k < 60 && !seen; k++) begin
                cyc(); lat++;
                if (gap_done) seen = 1;
            end
            check("R6", $sformatf("latency sel %0d", s), lat, BASE * (1 << s) + 1);
            run(3);
        end

        // R7/R8: sweep select, tick rate, memory delay
        cur_req = "R7";
        for (int s = 0; s < 4; s++)
            for (int d = 1; d <= 2; d++)
                for (int md = 0; md < 2; md++) begin
                    tick_div = d; gap_sel = 2'(s); mem_ready = (md == 0);
                    msg_done = 1; cyc(); msg_done = 0;
                    run(BASE * (1 << s) * d + 6);
                    mem_ready = 1; run(5);
                end
        cur_req = "R8"; tick_div = 1; gap_sel = 0;
        msg_done = 1; cyc(); msg_done = 0; run(12);

        // R10: restart mid-gap
        cur_req = "R10"; gap_sel = 3; msg_done = 1; cyc(); msg_done = 0; run(10);
        gap_sel = 0; msg_done = 1; cyc(); msg_done = 0; run(40);

        // R9: no gap_done while shut down
        cur_req = "R9"; tx_active = 1; run(LIMIT + 2); tx_active = 0;
        check("R9", "shutdown set", shutdown, 1);
        gap_sel = 0; mem_ready = 1; msg_done = 1; cyc(); msg_done = 0; run(40);
        check("R9", "gap_done held off", gap_done, 0);
        do_start(); run(5);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule